// File: doc/BRIEF.md
# Bus Function-Code Access Monitor

This block sits beside a processor bus whose cycles carry a 3-bit function code next to the address. It sorts every bus cycle by the code into one of the address spaces: user data, user program, supervisor data, supervisor program, CPU space or a reserved code. It then checks the cycle against three rule classes. The first covers reserved codes, the second covers writes by a user-level issuer, and the third covers writes by a supervisor-level issuer.

A cycle that breaks a rule can be blocked, logged and raised as an interrupt. A separate enable bit per class controls each of these three actions. The deny output is combinational, so it is valid within the same bus cycle, in time for the data-strobe logic to suppress the write. The log keeps the first violation only: its code, its address and its direction. Later violations only set an overflow bit, until a clear pulse empties the log.

The issuer's privilege level is a separate input. With that input, a user-level program that reaches supervisor space through an alternate-space move can be told apart from a supervisor-level cycle.

Top module: `fcm_access_monitor`

## Requirements
- R1: A cycle with code 111 (CPU space) is never denied, logged or raised as an interrupt, whatever the direction, privilege or enables.
- R2: A cycle with code 000, 011 or 100 is a class-0 violation for reads and writes alike. Class 0 is enable bit 0.
- R3: A write with `issuer_sup`=0 is a class-1 violation when the code is 010, 101 or 110. Class 1 is enable bit 1. User-level reads, and user-level writes with code 001, are not violations.
- R4: A write with `issuer_sup`=1 is a class-2 violation when the code is 110, 010 or 001. Class 2 is enable bit 2. Supervisor-level writes with code 101, and all supervisor-level reads, are not violations.
- R5: `acc_deny` is high in the same cycle as `bus_as` exactly when the cycle's violation class has its bit set in `cfg_block`. It is low whenever `bus_as` is low.
- R6: The first clock edge with `bus_as` high is the qualifying edge. If at that edge the cycle violates a class enabled in `cfg_log` and the log is empty, the code, address and direction are captured, and `log_valid` is high from that edge on.
- R7: Once `log_valid` is high, the captured fields do not change. A further violation that would be logged sets `log_ovf` instead.
- R8: `viol_irq` goes high at the qualifying edge of a violation whose class is enabled in `cfg_irq`, and stays high until it is cleared.
- R9: `log_clear` high at an edge clears `log_valid`, `log_ovf` and `viol_irq`. The clear wins over a capture, overflow or interrupt event at the same edge.
- R10: After reset, `log_valid`, `log_ovf` and `viol_irq` are low.
- R11: One bus cycle is one event: holding `bus_as` high over several clocks logs or counts the violation only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_as | input | 1 | Address strobe, high while a bus cycle is valid |
| bus_wr | input | 1 | Direction, 1 = write |
| bus_fc | input | 3 | Function code of the cycle |
| bus_addr | input | AW | Address of the cycle |
| issuer_sup | input | 1 | Privilege level of the issuer, 1 = supervisor |
| cfg_block | input | 3 | Per-class block enables (bit = class) |
| cfg_log | input | 3 | Per-class log enables |
| cfg_irq | input | 3 | Per-class interrupt enables |
| log_clear | input | 1 | Clears log, overflow and interrupt |
| acc_deny | output | 1 | Combinational deny for the current cycle |
| viol_irq | output | 1 | Sticky violation interrupt |
| log_valid | output | 1 | Log holds a violation |
| log_ovf | output | 1 | A further logged violation was lost |
| log_fc | output | 3 | Captured function code |
| log_addr | output | AW | Captured address |
| log_wr | output | 1 | Captured direction |

## Verification
The hardest case to reach is the interaction of one event with the log's history. This covers overflow after a held entry, a clear that coincides with a qualifying edge, and a long strobe that must not count twice. The stimulus builds each of these on purpose from an empty log, with clear pulses placed by the bench. Classification is swept over all 32 code, direction and privilege combinations under all 8 enable masks. Each mask is rotated differently across block, log and interrupt, so that every action is seen separately from the others.

// File: rtl/fcm_pkg.sv
// Shared types for the function-code access monitor.
// Assumes a 3-bit function code and three rule classes.
package fcm_pkg;
    localparam int FC_W = 3;
    localparam int NCLS = 3;

    // Address space named by a function code.
    typedef enum logic [2:0] {
        SP_RSV      = 3'd0,
        SP_USR_DATA = 3'd1,
        SP_USR_PROG = 3'd2,
        SP_SUP_DATA = 3'd3,
        SP_SUP_PROG = 3'd4,
        SP_CPU      = 3'd5
    } space_e;

    // Bit index of each rule class in the enable vectors.
    localparam int CLS_RSV = 0;
    localparam int CLS_USR = 1;
    localparam int CLS_SUP = 2;
endpackage

// File: rtl/fcm_fc_decode.sv
// Decodes a function code into an address space and a one-hot violation
// class vector. Purely combinational.
// Assumes the code, direction and privilege are stable while the strobe is valid.
module fcm_fc_decode
    import fcm_pkg::*;
(
    input  logic [FC_W-1:0] fc,
    input  logic            wr,
    input  logic            sup,
    output space_e          space,
    output logic [NCLS-1:0] viol
);
    logic is_prog;
    logic is_sdata;
    logic is_udata;

    // Map the code to its address space.
    always_comb begin
        unique case (fc)
            3'b001:  space = SP_USR_DATA;
            3'b010:  space = SP_USR_PROG;
            3'b101:  space = SP_SUP_DATA;
            3'b110:  space = SP_SUP_PROG;
            3'b111:  space = SP_CPU;
            default: space = SP_RSV;
        endcase
    end

    assign is_prog  = (space == SP_USR_PROG) || (space == SP_SUP_PROG);
    assign is_sdata = (space == SP_SUP_DATA);
    assign is_udata = (space == SP_USR_DATA);

    // Apply the rule classes, at most one hit per cycle.
    always_comb begin
        viol = '0;
        if (space == SP_RSV) begin
            viol[CLS_RSV] = 1'b1;
        end else if (wr && !sup && (is_prog || is_sdata)) begin
            viol[CLS_USR] = 1'b1;
        end else if (wr && sup && (space == SP_SUP_PROG || space == SP_USR_PROG || is_udata)) begin
            viol[CLS_SUP] = 1'b1;
        end
    end
endmodule

// File: rtl/fcm_action_mask.sv
// Combines the violation vector with the per-class enables into the three
// actions. One gate row per class is built by generate.
// Assumes viol is one-hot or zero.
module fcm_action_mask
    import fcm_pkg::*;
(
    input  logic [NCLS-1:0] viol,
    input  logic [NCLS-1:0] en_block,
    input  logic [NCLS-1:0] en_log,
    input  logic [NCLS-1:0] en_irq,
    output logic            do_block,
    output logic            do_log,
    output logic            do_irq
);
    logic [NCLS-1:0] blk_v;
    logic [NCLS-1:0] log_v;
    logic [NCLS-1:0] irq_v;

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        assign blk_v[c] = viol[c] & en_block[c];
        assign log_v[c] = viol[c] & en_log[c];
        assign irq_v[c] = viol[c] & en_irq[c];
    end

    assign do_block = |blk_v;
    assign do_log   = |log_v;
    assign do_irq   = |irq_v;
endmodule

// File: rtl/fcm_log_unit.sv
// Detects the qualifying edge of the strobe and keeps the first-violation log,
// the overflow flag and the sticky interrupt.
// Assumes the strobe drops for at least one clock between bus cycles.
module fcm_log_unit #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic          want_log,
    input  logic          want_irq,
    input  logic          clear,
    input  logic [2:0]    in_fc,
    input  logic [AW-1:0] in_addr,
    input  logic          in_wr,
    output logic          valid,
    output logic          ovf,
    output logic          irq,
    output logic [2:0]    fc_q,
    output logic [AW-1:0] addr_q,
    output logic          wr_q
);
    logic strobe_q;
    logic evt;

    // Remember the strobe to find its first clock.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    assign evt = strobe & ~strobe_q;

    // Status flags: clear wins, otherwise capture or overflow, and interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            valid <= 1'b0;
            ovf   <= 1'b0;
            irq   <= 1'b0;
        end else begin
            if (evt && want_log) begin
                if (valid) ovf   <= 1'b1;
                else       valid <= 1'b1;
            end
            if (evt && want_irq) irq <= 1'b1;
        end
    end

    // Capture fields of the first logged violation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fc_q   <= '0;
            addr_q <= '0;
            wr_q   <= 1'b0;
        end else if (!clear && evt && want_log && !valid) begin
            fc_q   <= in_fc;
            addr_q <= in_addr;
            wr_q   <= in_wr;
        end
    end
endmodule

// File: rtl/fcm_access_monitor.sv
// Top of the function-code access monitor: decode, per-class action masks,
// and the violation log.
// Assumes bus_fc, bus_wr, bus_addr and issuer_sup are valid while bus_as is high.
module fcm_access_monitor
    import fcm_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_as,
    input  logic            bus_wr,
    input  logic [2:0]      bus_fc,
    input  logic [AW-1:0]   bus_addr,
    input  logic            issuer_sup,
    input  logic [2:0]      cfg_block,
    input  logic [2:0]      cfg_log,
    input  logic [2:0]      cfg_irq,
    input  logic            log_clear,
    output logic            acc_deny,
    output logic            viol_irq,
    output logic            log_valid,
    output logic            log_ovf,
    output logic [2:0]      log_fc,
    output logic [AW-1:0]   log_addr,
    output logic            log_wr
);
    space_e          space;
    logic [NCLS-1:0] viol;
    logic            do_block;
    logic            do_log;
    logic            do_irq;

    fcm_fc_decode u_dec (
        .fc    (bus_fc),
        .wr    (bus_wr),
        .sup   (issuer_sup),
        .space (space),
        .viol  (viol)
    );

    fcm_action_mask u_mask (
        .viol     (viol),
        .en_block (cfg_block),
        .en_log   (cfg_log),
        .en_irq   (cfg_irq),
        .do_block (do_block),
        .do_log   (do_log),
        .do_irq   (do_irq)
    );

    // Deny is combinational so that the write can still be suppressed.
    assign acc_deny = bus_as & do_block;

    fcm_log_unit #(.AW(AW)) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (bus_as),
        .want_log (do_log),
        .want_irq (do_irq),
        .clear    (log_clear),
        .in_fc    (bus_fc),
        .in_addr  (bus_addr),
        .in_wr    (bus_wr),
        .valid    (log_valid),
        .ovf      (log_ovf),
        .irq      (viol_irq),
        .fc_q     (log_fc),
        .addr_q   (log_addr),
        .wr_q     (log_wr)
    );
endmodule

// File: rtl/fcm_access_monitor_chk.sv
// Assertion checker for the function-code access monitor, bound to the top.
// Observes ports only.
module fcm_access_monitor_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_as,
    input logic          bus_wr,
    input logic [2:0]    bus_fc,
    input logic [AW-1:0] bus_addr,
    input logic          issuer_sup,
    input logic [2:0]    cfg_block,
    input logic          log_clear,
    input logic          acc_deny,
    input logic          viol_irq,
    input logic          log_valid,
    input logic          log_ovf,
    input logic [2:0]    log_fc,
    input logic [AW-1:0] log_addr,
    input logic          log_wr
);
    AST_CPU_SPACE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_fc == 3'b111) |-> !acc_deny); // R1
    AST_RSV_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_as && cfg_block[0] && (bus_fc == 3'b000 || bus_fc == 3'b011 || bus_fc == 3'b100))
        |-> acc_deny); // R2
    AST_USER_PROG_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_as && bus_wr && !issuer_sup && cfg_block[1] && bus_fc == 3'b010) |-> acc_deny); // R3
    AST_SUP_DATA_WRITE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (issuer_sup && bus_fc == 3'b101) |-> !acc_deny); // R4
    AST_NO_DENY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_as |-> !acc_deny); // R5
    AST_LOG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (log_valid && !log_clear) |=> (log_valid && $stable(log_fc) && $stable(log_addr) && $stable(log_wr))); // R7
    AST_OVF_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        log_ovf |-> log_valid); // R7
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_irq && !log_clear) |=> viol_irq); // R8
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        log_clear |=> (!log_valid && !log_ovf && !viol_irq)); // R9
endmodule

bind fcm_access_monitor fcm_access_monitor_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_as     (bus_as),
    .bus_wr     (bus_wr),
    .bus_fc     (bus_fc),
    .bus_addr   (bus_addr),
    .issuer_sup (issuer_sup),
    .cfg_block  (cfg_block),
    .log_clear  (log_clear),
    .acc_deny   (acc_deny),
    .viol_irq   (viol_irq),
    .log_valid  (log_valid),
    .log_ovf    (log_ovf),
    .log_fc     (log_fc),
    .log_addr   (log_addr),
    .log_wr     (log_wr)
);

// File: tb/test_fcm_access_monitor.sv
// Bench: sweeps all code/direction/privilege combinations under all enable masks.
module test_fcm_access_monitor;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_as = 1'b0;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_fc = '0;
    logic [AW-1:0] bus_addr = '0;
    logic          issuer_sup = 1'b0;
    logic [2:0]    cfg_block = '0;
    logic [2:0]    cfg_log = '0;
    logic [2:0]    cfg_irq = '0;
    logic          log_clear = 1'b0;
    logic          acc_deny;
    logic          viol_irq;
    logic          log_valid;
    logic          log_ovf;
    logic [2:0]    log_fc;
    logic [AW-1:0] log_addr;
    logic          log_wr;

    int errors = 0;
    int checks = 0;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    fcm_access_monitor #(.AW(AW)) i_fcm_access_monitor (
        .clk(clk), .rst_n(rst_n), .bus_as(bus_as), .bus_wr(bus_wr),
        .bus_fc(bus_fc), .bus_addr(bus_addr), .issuer_sup(issuer_sup),
        .cfg_block(cfg_block), .cfg_log(cfg_log), .cfg_irq(cfg_irq),
        .log_clear(log_clear), .acc_deny(acc_deny), .viol_irq(viol_irq),
        .log_valid(log_valid), .log_ovf(log_ovf), .log_fc(log_fc),
        .log_addr(log_addr), .log_wr(log_wr)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected class vector, from R1..R4.
    function automatic logic [2:0] exp_cls(input logic [2:0] fc, input logic wr, input logic sup);
        if (fc == 3'd7) return 3'b000;
        if (fc == 3'd0 || fc == 3'd3 || fc == 3'd4) return 3'b001;
        if (wr && !sup && (fc == 3'd2 || fc == 3'd5 || fc == 3'd6)) return 3'b010;
        if (wr && sup && (fc == 3'd6 || fc == 3'd2 || fc == 3'd1)) return 3'b100;
        return 3'b000;
    endfunction

    task automatic do_clear();
        @(negedge clk); log_clear = 1'b1;
        @(negedge clk); log_clear = 1'b0;
    endtask

    // One bus cycle: strobe held for 'hold' clocks; deny sampled after drive.
    task automatic bus_cycle(input logic [2:0] fc, input logic wr, input logic sup,
                             input logic [AW-1:0] a, input int hold, output logic dn);
        @(negedge clk);
        bus_fc = fc; bus_wr = wr; issuer_sup = sup; bus_addr = a; bus_as = 1'b1;
        #1 dn = acc_deny;
        repeat (hold) @(negedge clk);
        bus_as = 1'b0;
        #1;
    endtask

    // Sweep every code, direction and privilege under one enable set.
    task automatic sweep(input logic [2:0] blk, input logic [2:0] lg, input logic [2:0] iq);
        logic dn;
        cfg_block = blk; cfg_log = lg; cfg_irq = iq;
        for (int i = 0; i < 32; i++) begin
            logic [2:0] fc = i[2:0];
            logic wr = i[3];
            logic sup = i[4];
            logic [2:0] cls = exp_cls(fc, wr, sup);
            logic [AW-1:0] a = AW'(i * 24'h0a3b1 + 24'h100);
            string rq = (fc == 3'd7) ? "R1" : (cls[0] ? "R2" : (sup ? "R4" : "R3"));
            do_clear();
            bus_cycle(fc, wr, sup, a, 1, dn);
            check(rq, "deny R5", dn, |(cls & blk));
            check(rq, "log_valid R6", log_valid, |(cls & lg));
            check(rq, "irq R8", viol_irq, |(cls & iq));
            check("R7", "ovf", log_ovf, 0);
            if (|(cls & lg)) begin
                check("R6", "log_fc", log_fc, fc);
                check("R6", "log_addr", log_addr, a);
                check("R6", "log_wr", log_wr, wr);
            end
            @(negedge clk);
            check("R5", "deny idle", acc_deny, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic dn;
        repeat (3) @(negedge clk);
        check("R10", "log_valid", log_valid, 0);
        check("R10", "log_ovf", log_ovf, 0);
        check("R10", "viol_irq", viol_irq, 0);
        check("R10", "deny", acc_deny, 0);
        rst_n = 1'b1;

        // Full sweep with every action on, then each mask rotated across the actions.
        sweep(3'b111, 3'b111, 3'b111);
        for (int k = 0; k < 8; k++) begin
            logic [2:0] m = k[2:0];
            sweep(m, {m[1:0], m[2]}, {m[0], m[2:1]});
        end

        // Overflow: the first entry is held, the second violation only sets overflow.
        cfg_block = 3'b111; cfg_log = 3'b111; cfg_irq = 3'b111;
        do_clear();
        bus_cycle(3'd0, 1'b0, 1'b0, 24'h000111, 1, dn);
        bus_cycle(3'd2, 1'b1, 1'b0, 24'h000222, 1, dn);
        check("R7", "ovf set", log_ovf, 1);
        check("R7", "addr held", log_addr, 24'h000111);
        check("R7", "fc held", log_fc, 3'd0);
        check("R7", "wr held", log_wr, 0);

        // A CPU-space cycle does not add overflow or change the log.
        do_clear();
        bus_cycle(3'd6, 1'b1, 1'b1, 24'h000333, 1, dn);
        bus_cycle(3'd7, 1'b1, 1'b0, 24'h000444, 1, dn);
        check("R1", "cpu no deny", dn, 0);
        check("R1", "cpu no ovf", log_ovf, 0);
        check("R1", "cpu log kept", log_addr, 24'h000333);

        // A long strobe is one event.
        do_clear();
        bus_cycle(3'd3, 1'b1, 1'b1, 24'h000555, 6, dn);
        check("R11", "long valid", log_valid, 1);
        check("R11", "long ovf", log_ovf, 0);

        // The clear wins over a capture at the same edge.
        do_clear();
        @(negedge clk);
        bus_fc = 3'd4; bus_wr = 1'b0; issuer_sup = 1'b0; bus_addr = 24'h000666;
        bus_as = 1'b1; log_clear = 1'b1;
        @(negedge clk);
        log_clear = 1'b0;
        check("R9", "clear wins valid", log_valid, 0);
        check("R9", "clear wins irq", viol_irq, 0);
        @(negedge clk);
        check("R11", "no second capture", log_valid, 0);
        bus_as = 1'b0;

        // The clear empties a full log with overflow.
        bus_cycle(3'd0, 1'b1, 1'b0, 24'h000777, 1, dn);
        bus_cycle(3'd0, 1'b1, 1'b0, 24'h000888, 1, dn);
        check("R7", "ovf before clear", log_ovf, 1);
        do_clear();
        check("R9", "cleared valid", log_valid, 0);
        check("R9", "cleared ovf", log_ovf, 0);
        check("R9", "cleared irq", viol_irq, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule